// File: doc/BRIEF.md
# Device-Side Burst Receive Sequencer

This block sits on the device side of a memory-to-device DMA path. Software sets it up through four word registers. It programs a destination address in device memory and a length in bytes, then sets a start bit. From that point the sequencer holds a request line to the DMA channel high. For each 32-byte burst the channel acknowledges, it moves the write pointer forward by one burst and lowers the remaining byte count by 32.

When the count reaches zero, the start bit clears by itself and the request drops. A one-cycle completion pulse goes to the event controller that software waits on. Software can abort a transfer early by writing zero to the control register; an aborted transfer never raises the completion pulse. The destination register keeps its programmed value through the whole transfer. The region register accepts writes but always reads back zero.

Top module: `dev_dma_rx`

## Requirements
- R1: After synchronous active-low reset, every register reads 0, and `burst_req` and `done_pulse` are low.
- R2: While idle, the destination register (offset 0x800) and the byte-count register (offset 0x804) read back the last value written. The region register (offset 0x884) reads 0 whatever was written. An unmapped offset reads 0.
- R3: Writing a value with bit 0 set to the control register (offset 0x808) while idle with a nonzero count starts a transfer. In the next cycle the control register reads 1 and `burst_req` is high. If the count is 0, the start write is ignored.
- R4: Each cycle with `burst_req` and `burst_ack` both high lowers the count by 32, saturating at 0. A count that is not a multiple of 32 therefore takes ceil(count/32) bursts. While the k-th burst (k from 0) is requested, `mem_addr` equals destination + 32*k.
- R5: In the cycle after the burst that takes the count to 0, the control register reads 0, the count reads 0, `burst_req` is low, and `done_pulse` is high for exactly one cycle.
- R6: Writing a value with bit 0 clear to the control register during a transfer stops it. In the next cycle `burst_req` is low, control reads 0, the count keeps its remaining value, and no `done_pulse` is issued. An acknowledge in the same cycle as the stop write is not counted.
- R7: During a transfer, writes to the destination or count register and further start writes are ignored. The destination reads its programmed value after completion.
- R8: `burst_ack` while no transfer is active changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset; also selects the read data |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| burst_req | output | 1 | Request for the next 32-byte burst |
| burst_ack | input | 1 | Channel delivers one burst this cycle |
| mem_addr | output | 32 | Device memory address of the current burst |
| done_pulse | output | 1 | One-cycle completion event |

## Verification
The bench sweeps lengths from one to eight bursts, plus lengths that are not multiples of 32, with acknowledge gaps of zero to two cycles.

- A counter that wraps instead of saturating would leave a huge count and keep requesting.
- A pointer that misses a step would show a wrong `mem_addr`.
- A pulse that comes a cycle late or lasts two cycles is caught at the pulse itself.
- An abort that also raised the completion event, or that counted a same-cycle acknowledge, shows up in the event tally or in the remaining count.
- Writes during a transfer and a start with a zero count are probed through read-back, to catch a design that lets them through.

// File: rtl/dev_dma_rx_pkg.sv
// Shared constants for the burst receive sequencer.
// Assumes a 12-bit register byte offset within the device window.
package dev_dma_rx_pkg;
    localparam int REG_AW = 12;
    localparam logic [REG_AW-1:0] OFS_DEST   = 12'h800;
    localparam logic [REG_AW-1:0] OFS_COUNT  = 12'h804;
    localparam logic [REG_AW-1:0] OFS_CTRL   = 12'h808;
    localparam logic [REG_AW-1:0] OFS_REGION = 12'h884;
endpackage

// File: rtl/dev_dma_rx_decode.sv
// Register write decoder: turns the write strobe and offset into one
// strobe per writable register. Assumes at most one write per cycle.
module dev_dma_rx_decode
    import dev_dma_rx_pkg::*;
(
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    output logic              wr_dest,
    output logic              wr_count,
    output logic              wr_ctrl
);
    // Compare the offset against each register that holds state.
    always_comb begin
        wr_dest  = reg_wr && (reg_addr == OFS_DEST);
        wr_count = reg_wr && (reg_addr == OFS_COUNT);
        wr_ctrl  = reg_wr && (reg_addr == OFS_CTRL);
    end
endmodule

// File: rtl/dev_dma_rx_ctrl.sv
// Transfer controller: holds the run flag and the remaining byte count,
// accepts bursts, and issues the completion pulse. Assumes the channel
// acknowledges only while the request is high; any other ack is ignored.
module dev_dma_rx_ctrl #(
    parameter int CNT_W       = 32,
    parameter int BURST_BYTES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_count,
    input  logic             wr_ctrl,
    input  logic             ctrl_bit,
    input  logic [CNT_W-1:0] wdata,
    input  logic             burst_ack,
    output logic             active,
    output logic [CNT_W-1:0] count,
    output logic             start,
    output logic             beat,
    output logic             done_pulse
);
    localparam logic [CNT_W-1:0] BURST = CNT_W'(BURST_BYTES);

    logic             active_q;
    logic [CNT_W-1:0] count_q;
    logic             done_q;
    logic             stop;

    // Qualify start, stop and burst acceptance from the current state.
    always_comb begin
        start = wr_ctrl && ctrl_bit && !active_q && (count_q != '0);
        stop  = wr_ctrl && !ctrl_bit && active_q;
        beat  = active_q && burst_ack && !stop;
    end

    // Run flag, byte counter and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            count_q  <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (stop) begin
                active_q <= 1'b0;
            end else if (start) begin
                active_q <= 1'b1;
            end else if (beat) begin
                if (count_q <= BURST) begin
                    count_q  <= '0;
                    active_q <= 1'b0;
                    done_q   <= 1'b1;
                end else begin
                    count_q <= count_q - BURST;
                end
            end else if (wr_count && !active_q) begin
                count_q <= wdata;
            end
        end
    end

    assign active     = active_q;
    assign count      = count_q;
    assign done_pulse = done_q;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R5
    AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (count_q == '0) && !active_q); // R5
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && count_q > BURST) |=> (count_q == $past(count_q) - BURST)); // R4
    AST_STOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (!active_q && !done_q && $stable(count_q))); // R6
    AST_IDLE_ACK_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_q && !wr_count && !wr_ctrl) |=> $stable(count_q)); // R8
endmodule

// File: rtl/dev_dma_rx_addr.sv
// Destination pointer: holds the programmed target and the byte offset of
// the current burst. Assumes start and beat never coincide.
module dev_dma_rx_addr #(
    parameter int ADDR_W      = 32,
    parameter int BURST_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_dest,
    input  logic [ADDR_W-1:0] wdata,
    input  logic              active,
    input  logic              start,
    input  logic              beat,
    output logic [ADDR_W-1:0] dest,
    output logic [ADDR_W-1:0] mem_addr
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BURST_BYTES);

    logic [ADDR_W-1:0] dest_q;
    logic [ADDR_W-1:0] offset_q;

    // Destination register, frozen while a transfer runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dest_q <= '0;
        end else if (wr_dest && !active) begin
            dest_q <= wdata;
        end
    end

    // Burst offset: cleared on start, advanced per accepted burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            offset_q <= '0;
        end else if (start) begin
            offset_q <= '0;
        end else if (beat) begin
            offset_q <= offset_q + STEP;
        end
    end

    assign dest     = dest_q;
    assign mem_addr = dest_q + offset_q;

    AST_DEST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        active |=> $stable(dest_q)); // R7
    AST_OFFSET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (offset_q == '0)); // R4
endmodule

// File: rtl/dev_dma_rx.sv
// Top of the burst receive sequencer: register decode, controller, pointer
// and the read-back multiplexer. Assumes reads are combinational on reg_addr.
module dev_dma_rx
    import dev_dma_rx_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int BURST_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              burst_req,
    input  logic              burst_ack,
    output logic [DATA_W-1:0] mem_addr,
    output logic              done_pulse
);
    logic              wr_dest, wr_count, wr_ctrl;
    logic              active, start, beat;
    logic [DATA_W-1:0] count, dest;

    dev_dma_rx_decode u_dec (
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .wr_dest  (wr_dest),
        .wr_count (wr_count),
        .wr_ctrl  (wr_ctrl)
    );

    dev_dma_rx_ctrl #(.CNT_W(DATA_W), .BURST_BYTES(BURST_BYTES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_count   (wr_count),
        .wr_ctrl    (wr_ctrl),
        .ctrl_bit   (reg_wdata[0]),
        .wdata      (reg_wdata),
        .burst_ack  (burst_ack),
        .active     (active),
        .count      (count),
        .start      (start),
        .beat       (beat),
        .done_pulse (done_pulse)
    );

    dev_dma_rx_addr #(.ADDR_W(DATA_W), .BURST_BYTES(BURST_BYTES)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_dest  (wr_dest),
        .wdata    (reg_wdata),
        .active   (active),
        .start    (start),
        .beat     (beat),
        .dest     (dest),
        .mem_addr (mem_addr)
    );

    // Request follows the run flag.
    assign burst_req = active;

    // Read-back mux; the region register and unmapped offsets read zero.
    always_comb begin
        case (reg_addr)
            OFS_DEST:  reg_rdata = dest;
            OFS_COUNT: reg_rdata = count;
            OFS_CTRL:  reg_rdata = {{(DATA_W-1){1'b0}}, active};
            default:   reg_rdata = '0;
        endcase
    end

    AST_REQ_DROPS_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> !burst_req); // R5
    AST_START_RAISES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> burst_req); // R3
endmodule

// File: tb/sim_dev_dma_rx.sv
module sim_dev_dma_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = 12'h000;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        burst_req;
    logic        burst_ack = 1'b0;
    logic [31:0] mem_addr;
    logic        done_pulse;

    int n_chk = 0;
    int n_bad = 0;
    int n_done = 0;
    int cycles = 0;
    bit reported = 0;

    localparam logic [11:0] A_DEST = 12'h800, A_CNT = 12'h804,
                            A_CTL = 12'h808, A_REG = 12'h884;

    always #10 clk = ~clk;

    dev_dma_rx u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .burst_req(burst_req),
        .burst_ack(burst_ack), .mem_addr(mem_addr), .done_pulse(done_pulse)
    );

    task automatic summary();
        if (!reported) begin
            reported = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        end
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            summary();
        end
    end

    always @(negedge clk) if (rst_n && done_pulse) n_done++;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // Full transfer of len bytes, gap idle cycles before each ack.
    task automatic run(logic [31:0] dst, int len, int gap, bit poke);
        int nb;
        logic [31:0] v;
        int d0;
        nb = (len + 31) / 32;
        wr(A_DEST, dst);
        wr(A_CNT, len);
        wr(A_CTL, 32'h1);
        check("R3 req after start", burst_req, 1);
        rd(A_CTL, v); check("R3 ctrl reads 1", v, 1);
        d0 = n_done;
        for (int k = 0; k < nb; k++) begin
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                check("R4 req held during gap", burst_req, 1);
            end
            if (poke && k == 1) begin
                wr(A_DEST, 32'hDEAD_0000);
                wr(A_CNT, 32'h7777);
                wr(A_CTL, 32'h1);
                rd(A_CNT, v); check("R7 count write ignored", v, len - 32);
            end
            check("R4 mem_addr", mem_addr, dst + 32 * k);
            burst_ack = 1'b1;
            @(negedge clk);
            burst_ack = 1'b0;
            rd(A_CNT, v);
            check("R4 count step", v, (len - 32 * (k + 1) > 0) ? len - 32 * (k + 1) : 0);
            if (k == nb - 1) begin
                check("R5 done pulse", done_pulse, 1);
                check("R5 req low", burst_req, 0);
                rd(A_CTL, v); check("R5 ctrl self-clear", v, 0);
            end else begin
                check("R4 no early done", done_pulse, 0);
            end
        end
        @(negedge clk);
        check("R5 pulse one cycle", done_pulse, 0);
        check("R5 one event", n_done - d0, 1);
        rd(A_DEST, v); check("R7 dest kept", v, dst);
    endtask

    initial begin
        logic [31:0] v;
        int d0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 req", burst_req, 0);
        check("R1 done", done_pulse, 0);
        rd(A_DEST, v); check("R1 dest", v, 0);
        rd(A_CNT, v);  check("R1 count", v, 0);
        rd(A_CTL, v);  check("R1 ctrl", v, 0);

        wr(A_DEST, 32'h1234_5678); rd(A_DEST, v); check("R2 dest rb", v, 32'h1234_5678);
        wr(A_CNT, 32'h0000_0140);  rd(A_CNT, v);  check("R2 count rb", v, 32'h140);
        wr(A_REG, 32'hFFFF_FFFF);  rd(A_REG, v);  check("R2 region zero", v, 0);
        rd(12'h810, v); check("R2 unmapped", v, 0);

        // R8: ack while idle leaves the count alone.
        burst_ack = 1'b1; @(negedge clk); burst_ack = 1'b0;
        rd(A_CNT, v); check("R8 idle ack", v, 32'h140);

        // Sweep bursts 1..8 with ack gaps 0..2.
        for (int nb = 1; nb <= 8; nb++)
            for (int gap = 0; gap <= 2; gap++)
                run(32'h0010_0000 + nb * 32'h1000 + gap * 32'h100, nb * 32, gap, 1'b0);
        // Residue lengths round up.
        run(32'h0020_0000, 33, 0, 1'b0);
        run(32'h0020_1000, 63, 1, 1'b0);
        run(32'h0020_2000, 1, 0, 1'b0);
        // Writes during a transfer are ignored.
        run(32'h0030_0000, 128, 0, 1'b1);

        // R3: start with zero count ignored.
        wr(A_CTL, 32'h1);
        check("R3 zero count no req", burst_req, 0);
        rd(A_CTL, v); check("R3 zero count ctrl", v, 0);

        // R6: abort with a same-cycle ack.
        wr(A_DEST, 32'h0040_0000);
        wr(A_CNT, 256);
        wr(A_CTL, 32'h1);
        for (int k = 0; k < 2; k++) begin
            burst_ack = 1'b1; @(negedge clk); burst_ack = 1'b0;
        end
        d0 = n_done;
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = A_CTL; reg_wdata = 32'h0; burst_ack = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; burst_ack = 1'b0;
        check("R6 req drops", burst_req, 0);
        rd(A_CTL, v); check("R6 ctrl 0", v, 0);
        rd(A_CNT, v); check("R6 count kept", v, 256 - 64);
        repeat (3) @(negedge clk);
        check("R6 no event", n_done - d0, 0);
        rd(A_DEST, v); check("R6 dest kept", v, 32'h0040_0000);

        summary();
    end
endmodule